// File: doc/BRIEF.md
# H-Bridge Gate Control Sequencer

This block is the digital core of a full-bridge DC motor driver. It takes four control inputs: direction, drive enable, decay-mode select and an active-low sleep request. It also takes a zero-current flag from the load-current sensor, two supply fault flags and two sampled analog codes, one for die temperature and one for load supply voltage. From these it produces the four gate commands of the bridge: the high-side and low-side switch of leg A, and the same pair for leg B.

All single-bit inputs are asynchronous. Each passes through a two-flop synchronizer before it is decoded. The decoder selects one of four bridge states:
- forward or reverse drive;
- slow-decay braking, with both low sides on;
- synchronous fast decay, with the polarity opposite to the drive.

Each leg has its own sequencer. A leg turns a switch off at once. It turns a switch on only after a programmable crossover dead time in which both of its switches are off. The bridge is forced fully off in the following cases:
- while asleep;
- while a fault is present;
- during the supply-good settle delay after power-up or after a supply lockout;
- during the settle delay after waking up;
- during fast decay, once the zero-current flag has been seen.

The over-temperature and supply-lockout decisions are made inside the block, as hysteresis comparisons on the sampled codes.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With sleep released and enable high, direction 1 drives leg A high and leg B low. Direction 0 drives leg A low and leg B high. The mode input has no effect in either case. Gate vector {a_hi,a_lo,b_hi,b_lo} is 1001 for forward and 0110 for reverse.
- R2: With enable low and mode 1, both low sides are on (gate vector 0101) for either direction value.
- R3: With enable low and mode 0, the bridge applies the reverse of the drive polarity. Direction 1 gives 0110 and direction 0 gives 1001.
- R4: In fast decay, a zero-current flag seen for even one synchronized cycle turns all four switches off. The bridge stays off, across direction changes, until the decoded state leaves fast decay.
- R5: A low sleep input turns all four switches off, whatever the other inputs are.
- R6: Turning a switch off is never delayed. Turning a switch on happens only after at least DEAD_CYC consecutive cycles in which both switches of that leg were off. DEAD_CYC is the dead time in nanoseconds converted to clock cycles.
- R7: A leg's high-side and low-side commands are never asserted in the same cycle, and a leg never moves directly from one switch to the other, under any input sequence.
- R8: An active charge-pump-low or low-side-supply-low flag turns all switches off. Drive resumes as soon as the synchronized flag clears and the dead time has run.
- R9: Over-temperature trips when the temperature code is at or above OT_TRIP. It clears only when the code falls below OT_TRIP−OT_HYST. While it is tripped, all switches are off.
- R10: The supply lockout is active from reset. It releases when the supply code reaches UV_ON and re-engages only when the code falls below UV_ON−UV_HYST. While it is active, all switches are off.
- R11: After reset or a lockout release, the outputs stay off for the power-up settle time. After sleep is released, they stay off for the wake settle time. Both times are converted from microseconds to cycles.
- R12: A control input change reaches the synchronized decode after two clock edges. A resulting turn-off appears at the gate outputs on the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Direction request (asynchronous) |
| en | input | 1 | Drive enable (asynchronous) |
| mode | input | 1 | Decay select when not enabled: 1 slow, 0 fast (asynchronous) |
| sleep_n | input | 1 | Low requests sleep (asynchronous) |
| zero_cur | input | 1 | Load current near zero (asynchronous) |
| cp_low | input | 1 | Charge-pump supply undervoltage flag (asynchronous) |
| lsv_low | input | 1 | Low-side gate supply undervoltage flag (asynchronous) |
| temp_code | input | TEMP_W | Sampled die temperature code, synchronous |
| vbb_code | input | VBB_W | Sampled load-supply voltage code, synchronous |
| a_hi | output | 1 | Leg A high-side gate command |
| a_lo | output | 1 | Leg A low-side gate command |
| b_hi | output | 1 | Leg B high-side gate command |
| b_lo | output | 1 | Leg B low-side gate command |

## Verification
The hardest state to reach is the latched zero-current cutoff inside fast decay. Reaching it takes several steps: the supply code must first be raised past the lockout threshold, the power-up settle delay must pass, and enable must be dropped with mode 0. Only then does a single-cycle pulse on the current flag show that the latch holds across a direction change and is released only by leaving fast decay. The second hard case is a stream of direction and mode changes faster than the dead time. The bench drives such a stream in a long pseudo-random phase. The behavioural model is compared on every cycle, so any early turn-on is caught.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'b00,
        LEG_HIGH = 2'b01,
        LEG_LOW  = 2'b10
    } leg_e;

    typedef struct packed {
        leg_e a;
        leg_e b;
    } bridge_tgt_t;

    typedef struct packed {
        logic dir;
        logic en;
        logic mode;
        logic sleep_n;
        logic zc;
        logic cp_low;
        logic lsv_low;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic int cycles_for_ns(input int clk_hz, input int ns);
        int c;
        c = (clk_hz / 1_000_000) * ns / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int cycles_for_us(input int clk_hz, input int us);
        int c;
        c = (clk_hz / 1_000_000) * us;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic bridge_tgt_t decode_bridge(input logic dir, input logic en,
                                                  input logic mode);
        bridge_tgt_t t;
        if (en) begin
            t.a = dir ? LEG_HIGH : LEG_LOW;
            t.b = dir ? LEG_LOW  : LEG_HIGH;
        end else if (mode) begin
            t.a = LEG_LOW;
            t.b = LEG_LOW;
        end else begin
            t.a = dir ? LEG_LOW  : LEG_HIGH;
            t.b = dir ? LEG_HIGH : LEG_LOW;
        end
        return t;
    endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbg_hyst.sv
module hbg_hyst #(
    parameter int W         = 8,
    parameter int SET_AT    = 170,
    parameter int CLR_BELOW = 155,
    parameter bit RST_STATE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code,
    output logic         state
);
    always_ff @(posedge clk) begin
        if (rst)                       state <= RST_STATE;
        else if (code >= W'(SET_AT))   state <= 1'b1;
        else if (code < W'(CLR_BELOW)) state <= 1'b0;
    end

    // R9 / R10: threshold crossings move the comparator one edge later
    a_r9_set: assert property (@(posedge clk) disable iff (rst)
        (code >= W'(SET_AT)) |=> state);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (code < W'(CLR_BELOW)) |=> !state);
    // R10: inside the band the decision is held
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        ((code < W'(SET_AT)) && (code >= W'(CLR_BELOW))) |=> $stable(state));
endmodule

// File: rtl/hbg_settle.sv
module hbg_settle #(
    parameter int POR_CYC  = 20000,
    parameter int WAKE_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_por,
    input  logic hold_wake,
    output logic ready
);
    localparam int MAX_CYC = (POR_CYC > WAKE_CYC) ? POR_CYC : WAKE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold_por)  cnt <= CW'(POR_CYC);
        else if (hold_wake)   cnt <= CW'(WAKE_CYC);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);

    // R11: any hold request keeps the timer from reporting ready next cycle
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (hold_por || hold_wake) |=> !ready);
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  leg_e tgt,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    leg_e          cur;
    logic [DW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= LEG_OFF;
            dcnt <= DW'(DEAD_CYC - 1);
        end else if (cur != LEG_OFF) begin
            if (tgt != cur) begin
                cur  <= LEG_OFF;
                dcnt <= DW'(DEAD_CYC - 1);
            end
        end else if (dcnt != '0) begin
            dcnt <= dcnt - 1'b1;
        end else if (tgt != LEG_OFF) begin
            cur <= tgt;
        end
    end

    assign gate_hi = (cur == LEG_HIGH);
    assign gate_lo = (cur == LEG_LOW);

    // Checker state: consecutive cycles with both switches off, saturating
    logic [DW-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst)                          off_run <= DW'(DEAD_CYC);
        else if (gate_hi || gate_lo)      off_run <= '0;
        else if (off_run != DW'(DEAD_CYC)) off_run <= off_run + 1'b1;
    end

    // R6: every turn-on is preceded by a full dead window
    a_r6_dead_hi: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> (off_run >= DW'(DEAD_CYC)));
    a_r6_dead_lo: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> (off_run >= DW'(DEAD_CYC)));
    // R7: never a direct hand-over between the two switches of the leg
    a_r7_no_direct_hi: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> !$past(gate_lo));
    a_r7_no_direct_lo: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> !$past(gate_hi));
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int DEAD_NS = 500,
    parameter int WAKE_US = 1000,
    parameter int POR_US  = 200,
    parameter int TEMP_W  = 8,
    parameter int OT_TRIP = 170,
    parameter int OT_HYST = 15,
    parameter int VBB_W   = 8,
    parameter int UV_ON   = 120,
    parameter int UV_HYST = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir,
    input  logic              en,
    input  logic              mode,
    input  logic              sleep_n,
    input  logic              zero_cur,
    input  logic              cp_low,
    input  logic              lsv_low,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [VBB_W-1:0]  vbb_code,
    output logic              a_hi,
    output logic              a_lo,
    output logic              b_hi,
    output logic              b_lo
);
    localparam int DEAD_CYC = cycles_for_ns(CLK_HZ, DEAD_NS);
    localparam int WAKE_CYC = cycles_for_us(CLK_HZ, WAKE_US);
    localparam int POR_CYC  = cycles_for_us(CLK_HZ, POR_US);
    localparam int NLEG     = 2;

    // ---- input synchronization (R12)
    ctl_t             raw;
    ctl_t             sc;
    logic [CTL_W-1:0] sc_vec;

    always_comb begin
        raw.dir     = dir;
        raw.en      = en;
        raw.mode    = mode;
        raw.sleep_n = sleep_n;
        raw.zc      = zero_cur;
        raw.cp_low  = cp_low;
        raw.lsv_low = lsv_low;
    end

    hbg_sync #(.W(CTL_W), .RST_VAL('0)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(sc_vec)
    );
    assign sc = sc_vec;

    // ---- thermal and supply comparators with hysteresis (R9, R10)
    logic ot_hot;
    logic vbb_ok;

    hbg_hyst #(.W(TEMP_W), .SET_AT(OT_TRIP), .CLR_BELOW(OT_TRIP - OT_HYST),
               .RST_STATE(1'b0)) u_ot (
        .clk(clk), .rst(rst), .code(temp_code), .state(ot_hot)
    );

    hbg_hyst #(.W(VBB_W), .SET_AT(UV_ON), .CLR_BELOW(UV_ON - UV_HYST),
               .RST_STATE(1'b0)) u_uv (
        .clk(clk), .rst(rst), .code(vbb_code), .state(vbb_ok)
    );

    // ---- settle timer (R11)
    logic settle_ready;

    hbg_settle #(.POR_CYC(POR_CYC), .WAKE_CYC(WAKE_CYC)) u_settle (
        .clk(clk), .rst(rst), .hold_por(!vbb_ok), .hold_wake(!sc.sleep_n),
        .ready(settle_ready)
    );

    // ---- enable qualification
    logic fault_any;
    logic gate_en;
    logic fd_active;
    logic zc_lat;
    logic zc_cut;

    assign fault_any = ot_hot || !vbb_ok || sc.cp_low || sc.lsv_low;
    assign gate_en   = settle_ready && sc.sleep_n && !fault_any;
    assign fd_active = gate_en && !sc.en && !sc.mode;
    assign zc_cut    = fd_active && (sc.zc || zc_lat);

    // R4: zero-current cutoff holds while fast decay stays decoded
    always_ff @(posedge clk) begin
        if (rst) zc_lat <= 1'b0;
        else     zc_lat <= fd_active && (zc_lat || sc.zc);
    end

    // ---- bridge decode
    bridge_tgt_t tgt;
    leg_e        tgt_leg [NLEG];

    always_comb begin
        if (!gate_en || zc_cut) begin
            tgt.a = LEG_OFF;
            tgt.b = LEG_OFF;
        end else begin
            tgt = decode_bridge(sc.dir, sc.en, sc.mode);
        end
    end

    assign tgt_leg[0] = tgt.a;
    assign tgt_leg[1] = tgt.b;

    // ---- per-leg dead-time sequencers (R6, R7)
    logic [NLEG-1:0] hi_v;
    logic [NLEG-1:0] lo_v;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst(rst), .tgt(tgt_leg[g]),
            .gate_hi(hi_v[g]), .gate_lo(lo_v[g])
        );
    end

    assign a_hi = hi_v[0];
    assign a_lo = lo_v[0];
    assign b_hi = hi_v[1];
    assign b_lo = lo_v[1];

    logic [3:0] gates_w;
    assign gates_w = {a_hi, a_lo, b_hi, b_lo};

    // R5: synchronized sleep request clears every gate on the next edge
    a_r5_sleep_off: assert property (@(posedge clk) disable iff (rst)
        !sc.sleep_n |=> (gates_w == 4'b0000));
    // R8: any fault clears every gate on the next edge
    a_r8_fault_off: assert property (@(posedge clk) disable iff (rst)
        fault_any |=> (gates_w == 4'b0000));
    // R11: unfinished settle keeps the bridge off
    a_r11_settle_off: assert property (@(posedge clk) disable iff (rst)
        !settle_ready |=> (gates_w == 4'b0000));
    // R4: zero-current cutoff in fast decay clears every gate
    a_r4_zc_off: assert property (@(posedge clk) disable iff (rst)
        zc_cut |=> (gates_w == 4'b0000));
endmodule

// File: tb/sim_hbridge_gate_seq.sv
`timescale 1ns/1ps
module sim_hbridge_gate_seq;
    localparam int T_NS   = 20;
    localparam int DEAD   = 100 / T_NS;
    localparam int WAKE   = 2000 / T_NS;
    localparam int POR    = 3000 / T_NS;
    localparam int OT_SET = 170;
    localparam int OT_CLR = 155;
    localparam int UV_SET = 120;
    localparam int UV_CLR = 115;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir = 1'b1, en = 1'b1, mode = 1'b0, sleep_n = 1'b0;
    logic zero_cur = 1'b0, cp_low = 1'b0, lsv_low = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic [7:0] vbb_code  = 8'd0;
    logic a_hi, a_lo, b_hi, b_lo;

    always #(T_NS/2) clk = ~clk;

    hbridge_gate_seq #(
        .CLK_HZ(50_000_000), .DEAD_NS(100), .WAKE_US(2), .POR_US(3)
    ) u0 (
        .clk(clk), .rst(rst), .dir(dir), .en(en), .mode(mode), .sleep_n(sleep_n),
        .zero_cur(zero_cur), .cp_low(cp_low), .lsv_low(lsv_low),
        .temp_code(temp_code), .vbb_code(vbb_code),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
    );

    int    nchk = 0;
    int    nfail = 0;
    int    cyc = 0;
    string phase = "R10";

    // ---- behavioural reference model (0 off, 1 high, 2 low)
    logic [6:0] q1, q2;
    bit   m_ot, m_vok, m_zl;
    int   m_tmr;
    int   m_cur [2];
    int   m_dc  [2];
    int   tg    [2];
    bit   f_any, ok, fdm;

    always @(posedge clk) begin
        if (rst) begin
            q1 = '0; q2 = '0; m_ot = 0; m_vok = 0; m_zl = 0; m_tmr = POR;
            for (int g = 0; g < 2; g++) begin m_cur[g] = 0; m_dc[g] = DEAD - 1; end
        end else begin
            f_any = m_ot || !m_vok || q2[1] || q2[0];
            ok    = (m_tmr == 0) && q2[3] && !f_any;
            fdm   = ok && !q2[5] && !q2[4];
            if (!ok || (fdm && (q2[2] || m_zl))) begin
                tg[0] = 0; tg[1] = 0;
            end else if (q2[5]) begin
                tg[0] = q2[6] ? 1 : 2; tg[1] = q2[6] ? 2 : 1;
            end else if (q2[4]) begin
                tg[0] = 2; tg[1] = 2;
            end else begin
                tg[0] = q2[6] ? 2 : 1; tg[1] = q2[6] ? 1 : 2;
            end
            for (int g = 0; g < 2; g++) begin
                if (m_cur[g] != 0) begin
                    if (tg[g] != m_cur[g]) begin m_cur[g] = 0; m_dc[g] = DEAD - 1; end
                end else if (m_dc[g] != 0) m_dc[g]--;
                else if (tg[g] != 0) m_cur[g] = tg[g];
            end
            m_zl = fdm && (m_zl || q2[2]);
            if (!m_vok) m_tmr = POR;
            else if (!q2[3]) m_tmr = WAKE;
            else if (m_tmr > 0) m_tmr--;
            if (temp_code >= OT_SET) m_ot = 1; else if (temp_code < OT_CLR) m_ot = 0;
            if (vbb_code >= UV_SET) m_vok = 1; else if (vbb_code < UV_CLR) m_vok = 0;
            q2 = q1;
            q1 = {dir, en, mode, sleep_n, zero_cur, cp_low, lsv_low};
        end
    end

    function automatic logic [3:0] model_gates();
        return {m_cur[0] == 1, m_cur[0] == 2, m_cur[1] == 1, m_cur[1] == 2};
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            nchk++;
            if ({a_hi, a_lo, b_hi, b_lo} !== model_gates()) begin
                nfail++;
                $display("FAIL %s cycle %0d: gates=%b expected=%b", phase, cyc,
                         {a_hi, a_lo, b_hi, b_lo}, model_gates());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog (all requirements): cycle=%0d expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string tag);
        nchk++;
        if ({a_hi, a_lo, b_hi, b_lo} !== exp) begin
            nfail++;
            $display("FAIL %s directed: gates=%b expected=%b", tag,
                     {a_hi, a_lo, b_hi, b_lo}, exp);
        end
    endtask

    initial begin
        step(4);
        chk(4'b0000, "R10");                   // reset state: all off
        rst = 1'b0;

        // R10: supply below release threshold keeps bridge off
        phase = "R10";
        sleep_n = 1'b1;
        step(30);
        chk(4'b0000, "R10");
        // R11: power-up settle after lockout release
        phase = "R11";
        vbb_code = 8'd130;
        step(145); chk(4'b0000, "R11");
        step(10);  chk(4'b1001, "R11");

        // R1: drive, mode ignored
        phase = "R1";
        mode = 1'b1; step(10); chk(4'b1001, "R1");
        dir = 1'b0;  step(15); chk(4'b0110, "R1");
        mode = 1'b0; step(10); chk(4'b0110, "R1");

        // R6: reversal waits the full dead window
        phase = "R6";
        dir = 1'b1;
        step(3); chk(4'b0000, "R6");           // turn-off not delayed
        step(4); chk(4'b0000, "R6");
        step(1); chk(4'b1001, "R6");

        // R2: slow-decay brake for both directions
        phase = "R2";
        en = 1'b0; mode = 1'b1;
        step(15); chk(4'b0101, "R2");
        dir = 1'b0; step(10); chk(4'b0101, "R2");

        // R3: fast decay opposite polarity
        phase = "R3";
        mode = 1'b0; step(15); chk(4'b1001, "R3");
        dir = 1'b1;  step(15); chk(4'b0110, "R3");

        // R4: zero-current cutoff latches within fast decay
        phase = "R4";
        zero_cur = 1'b1; step(1); zero_cur = 1'b0;
        step(10); chk(4'b0000, "R4");
        step(20); chk(4'b0000, "R4");
        dir = 1'b0; step(15); chk(4'b0000, "R4");
        en = 1'b1;  step(15); chk(4'b0110, "R4");
        en = 1'b0;  step(15); chk(4'b1001, "R4");

        // R12: turn-off latency of three edges
        phase = "R12";
        en = 1'b1; step(15); chk(4'b0110, "R12");
        sleep_n = 1'b0;
        step(1); chk(4'b0110, "R12");
        step(1); chk(4'b0110, "R12");
        step(1); chk(4'b0000, "R12");

        // R5: sleep overrides every input combination
        phase = "R5";
        for (int k = 0; k < 8; k++) begin
            dir = k[0]; en = k[1]; mode = k[2];
            step(5); chk(4'b0000, "R5");
        end
        dir = 1'b1; en = 1'b1; mode = 1'b0; step(2);

        // R11: wake settle
        phase = "R11";
        sleep_n = 1'b1;
        step(WAKE + 2); chk(4'b0000, "R11");
        step(1);        chk(4'b1001, "R11");

        // R8: supply fault flags
        phase = "R8";
        cp_low = 1'b1;  step(4);  chk(4'b0000, "R8");
        cp_low = 1'b0;  step(10); chk(4'b1001, "R8");
        lsv_low = 1'b1; step(4);  chk(4'b0000, "R8");
        lsv_low = 1'b0; step(10); chk(4'b1001, "R8");

        // R9: thermal hysteresis
        phase = "R9";
        temp_code = 8'd169; step(5);  chk(4'b1001, "R9");
        temp_code = 8'd170; step(3);  chk(4'b0000, "R9");
        temp_code = 8'd160; step(20); chk(4'b0000, "R9");
        temp_code = 8'd154; step(10); chk(4'b1001, "R9");

        // R10: supply lockout hysteresis and re-entry
        phase = "R10";
        vbb_code = 8'd116; step(10);  chk(4'b1001, "R10");
        vbb_code = 8'd114; step(3);   chk(4'b0000, "R10");
        vbb_code = 8'd120; step(140); chk(4'b0000, "R11");
        step(20); chk(4'b1001, "R10");

        // R7 / R6: fast random stimulus compared every cycle
        phase = "R7";
        for (int i = 0; i < 4000; i++) begin
            dir  = $urandom_range(0, 1);
            en   = ($urandom_range(0, 3) != 0);
            mode = $urandom_range(0, 1);
            if ($urandom_range(0, 6) == 0)   dir = ~dir;
            zero_cur = ($urandom_range(0, 40) == 0);
            if ($urandom_range(0, 300) == 0) sleep_n = ~sleep_n;
            if ($urandom_range(0, 40) == 0)  sleep_n = 1'b1;
            cp_low  = ($urandom_range(0, 250) == 0);
            lsv_low = ($urandom_range(0, 250) == 0);
            temp_code = ($urandom_range(0, 300) == 0) ? 8'd180 : 8'd30;
            vbb_code  = ($urandom_range(0, 500) == 0) ? 8'd100 : 8'd130;
            step($urandom_range(1, 9));
        end
        step(20);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule